// File: doc/BRIEF.md
# Timer/Counter with Shared Assignable Prescaler

This block is an 8-bit timer/counter and a watchdog counter that share one 8-bit prescaler. A six-bit mode word selects the timer's count source (the instruction-cycle enable or edges of an already synchronized external pin). It also selects which edge of that pin counts and which of the two counters the prescaler serves. The last field is a three-bit divide code. The counter that does not own the prescaler advances on every one of its own events.

Software can load the timer through a write port. When the timer rolls over from its all-ones value to zero, it sets a sticky overflow flag, and a separate strobe clears that flag. The watchdog counter advances on prescaled or direct watchdog ticks. When it wraps, it emits a one-cycle timeout pulse. A watchdog clear command restarts the watchdog counter. Integration needs only a clock, a synchronous active-low reset, and the event inputs listed below.

Top module: `shared_presc_timer`

## Requirements
- R1: After a synchronous reset the timer value is 0, the overflow flag is 0, the timeout output is 0, and the prescaler and watchdog counts are 0.
- R2: With mode_cfg[5]=0 and mode_cfg[3]=1, the timer advances by one on every clock in which cyc_en is high.
- R3: With mode_cfg[5]=1 the timer counts edges of ext_pin and ignores cyc_en. mode_cfg[4]=1 selects high-to-low edges and mode_cfg[4]=0 selects low-to-high edges. An edge is found by comparing the pin with its value one clock earlier, so at most one count is taken per clock.
- R4: With mode_cfg[3]=0 the prescaler belongs to the timer, and the timer advances once per 2^(code+1) source events, where code is mode_cfg[2:0]. Codes 0 to 7 therefore give ratios 2 to 256.
- R5: With mode_cfg[3]=1 the prescaler belongs to the watchdog and divides wdt_tick by 2^code, giving ratios 1 to 128. In this mode the timer counts its source at 1:1.
- R6: A write (tmr_wr_en) loads tmr_wr_data, which is seen on tmr_value the next cycle, and the load wins over an increment in the same cycle. With mode_cfg[3]=0 the write also restarts the prescaler, so the next increment needs a full ratio of events.
- R7: An increment from all-ones to zero sets ovf_flag. The flag stays set until ovf_clr is asserted. If a rollover and ovf_clr fall in the same cycle, the flag ends up set.
- R8: wdt_clear zeroes the watchdog counter. It also restarts the prescaler only when mode_cfg[3]=1. A watchdog event taken while the watchdog counter is all ones wraps the counter and raises wdt_timeout for exactly one cycle, one clock later. A wdt_clear in that same cycle suppresses the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, the internal count source |
| ext_pin | input | 1 | Synchronized external count pin |
| wdt_tick | input | 1 | One-clock watchdog oscillator tick |
| wdt_clear | input | 1 | Watchdog clear command |
| mode_cfg | input | 6 | [5] external source, [4] falling edge, [3] prescaler to watchdog, [2:0] divide code |
| tmr_wr_en | input | 1 | Timer load strobe |
| tmr_wr_data | input | TMR_W | Timer load value |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| tmr_value | output | TMR_W | Current timer count |
| ovf_flag | output | 1 | Sticky rollover flag |
| wdt_timeout | output | 1 | One-cycle watchdog wrap pulse |

## Verification
Several pairs of actions can land on the same clock edge. A rollover can meet an overflow clear, and a timer load can meet a prescaled increment and a prescaler restart. A watchdog clear can meet the tick that would wrap the watchdog counter. Directed sequences place each pair on one edge on purpose: for example, loading all-ones and then raising the increment together with ovf_clr. Randomized stretches with rare strobes and changing mode words reach further combinations. Each cycle, the outputs are judged against a bench model of the rules: set beats clear for the flag, load beats increment, and clear beats wrap.

// File: rtl/spt_pkg.sv
// Shared types and helpers for the shared-prescaler timer.
// Assumes the mode word bit order: source, edge, owner, divide code.
package spt_pkg;

    localparam int PSC_W  = 8;
    localparam int RATE_W = 3;

    typedef struct packed {
        logic              src_ext;     // 1: count external pin edges
        logic              fall_edge;   // 1: high-to-low edges count
        logic              psc_to_wdt;  // 1: prescaler serves watchdog
        logic [RATE_W-1:0] rate;        // divide code
    } spt_cfg_t;

    localparam int CFG_W = $bits(spt_cfg_t);

    // Low-bit mask of the free-running prescaler count that must be all
    // ones for a divided event; the span is one octave larger for the timer.
    function automatic logic [PSC_W-1:0] tap_mask(input logic to_wdt,
                                                  input logic [RATE_W-1:0] rate);
        int unsigned span;
        span = to_wdt ? (32'd1 << rate) : (32'd2 << rate);
        return PSC_W'(span - 32'd1);
    endfunction

endpackage

// File: rtl/spt_clk_src.sv
// Count-source selector: picks the cycle enable or a detected pin edge.
// Assumes ext_pin is already synchronized to clk; gives one event per clock at most.
module spt_clk_src (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic ext_pin,
    input  logic src_ext,
    input  logic fall_edge,
    output logic src_evt
);

    logic pin_q;
    logic edge_hit;

    // Remember last sampled pin level (reset loads the live level: no false edge).
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= ext_pin;
        else        pin_q <= ext_pin;
    end

    // Edge compare and source selection.
    always_comb begin
        edge_hit = fall_edge ? (pin_q & ~ext_pin) : (~pin_q & ext_pin);
        src_evt  = src_ext ? edge_hit : cyc_en;
    end

    AST_EDGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && src_evt) |-> (ext_pin == !fall_edge)); // R3

endmodule

// File: rtl/spt_prescaler.sv
// Shared prescaler: a free-running count whose low bits are tapped by mask.
// Routes the divided event to the owner and passes the other input straight.
module spt_prescaler
    import spt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              tmr_src,
    input  logic              wdt_tick,
    input  logic              tmr_wr,
    input  logic              wdt_clear,
    output logic              tmr_evt,
    output logic              wdt_evt
);

    logic [PSC_W-1:0] cnt_q;
    logic [PSC_W-1:0] mask;
    logic             psc_in;
    logic             psc_out;
    logic             psc_clr;

    // Pick the owner's input, compute tap and restart condition.
    always_comb begin
        psc_in  = to_wdt ? wdt_tick : tmr_src;
        mask    = tap_mask(to_wdt, rate);
        psc_out = psc_in && ((cnt_q & mask) == mask);
        psc_clr = to_wdt ? wdt_clear : tmr_wr;
        tmr_evt = to_wdt ? tmr_src : psc_out;
        wdt_evt = to_wdt ? psc_out : wdt_tick;
    end

    // Prescaler count: restart beats advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (psc_clr) cnt_q <= '0;
        else if (psc_in)  cnt_q <= cnt_q + 1'b1;
    end

    AST_PSC_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_wdt && tmr_wr) |=> (cnt_q == '0)); // R6
    AST_PSC_WDT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (to_wdt && wdt_clear) |=> (cnt_q == '0)); // R8
    AST_TMR_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_wdt && tmr_evt) |-> tmr_src); // R4

endmodule

// File: rtl/spt_timer_core.sv
// Timer register with load port and sticky rollover flag.
// Assumes inc is a one-clock event; load has priority over increment.
module spt_timer_core #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] tmr_q,
    output logic             ovf_q
);

    localparam logic [TMR_W-1:0] TOP = '1;

    logic roll;

    // Rollover only on a real increment from all ones.
    always_comb roll = inc && !wr_en && (tmr_q == TOP);

    // Timer value: load, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)     tmr_q <= '0;
        else if (wr_en) tmr_q <= wr_data;
        else if (inc)   tmr_q <= tmr_q + 1'b1;
    end

    // Sticky flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= roll | (ovf_q & ~ovf_clr);
    end

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tmr_q == $past(wr_data))); // R6
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + 1'b1)); // R4
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q); // R7

endmodule

// File: rtl/spt_watchdog.sv
// Watchdog counter: wraps on events and emits a one-cycle timeout pulse.
// Assumes evt is a one-clock event; clear beats wrap.
module spt_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clear,
    output logic timeout
);

    localparam logic [WDT_W-1:0] TOP = '1;

    logic [WDT_W-1:0] cnt_q;

    // Watchdog count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (evt)   cnt_q <= cnt_q + 1'b1;
    end

    // Timeout pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) timeout <= 1'b0;
        else        timeout <= evt && !clear && (cnt_q == TOP);
    end

    AST_WDT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0 && !timeout)); // R8
    AST_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R8

endmodule

// File: rtl/shared_presc_timer.sv
// Top: timer/counter and watchdog sharing one assignable prescaler.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module shared_presc_timer
    import spt_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int WDT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             wdt_tick,
    input  logic             wdt_clear,
    input  logic [CFG_W-1:0] mode_cfg,
    input  logic             tmr_wr_en,
    input  logic [TMR_W-1:0] tmr_wr_data,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] tmr_value,
    output logic             ovf_flag,
    output logic             wdt_timeout
);

    spt_cfg_t cfg;
    logic     src_evt;
    logic     tmr_evt;
    logic     wdt_evt;

    // Decode the mode word.
    always_comb cfg = spt_cfg_t'(mode_cfg);

    spt_clk_src i_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .ext_pin   (ext_pin),
        .src_ext   (cfg.src_ext),
        .fall_edge (cfg.fall_edge),
        .src_evt   (src_evt)
    );

    spt_prescaler i_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .to_wdt    (cfg.psc_to_wdt),
        .rate      (cfg.rate),
        .tmr_src   (src_evt),
        .wdt_tick  (wdt_tick),
        .tmr_wr    (tmr_wr_en),
        .wdt_clear (wdt_clear),
        .tmr_evt   (tmr_evt),
        .wdt_evt   (wdt_evt)
    );

    spt_timer_core #(.TMR_W(TMR_W)) i_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tmr_evt),
        .wr_en   (tmr_wr_en),
        .wr_data (tmr_wr_data),
        .ovf_clr (ovf_clr),
        .tmr_q   (tmr_value),
        .ovf_q   (ovf_flag)
    );

    spt_watchdog #(.WDT_W(WDT_W)) i_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (wdt_evt),
        .clear   (wdt_clear),
        .timeout (wdt_timeout)
    );

    AST_ROLL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_value == '1 && !tmr_wr_en) |=> (tmr_value == '1 || ovf_flag)); // R7
    AST_UNOWNED_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cfg[3] && !mode_cfg[5] && cyc_en && !tmr_wr_en)
        |=> (tmr_value == $past(tmr_value) + 1'b1)); // R2

endmodule

// File: tb/test_shared_presc_timer.sv
module test_shared_presc_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WDT_W      = 4;
    localparam int TIMEOUT_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_en, ext_pin, wdt_tick, wdt_clear, tmr_wr_en, ovf_clr;
    logic [5:0] mode_cfg;
    logic [7:0] tmr_wr_data;
    logic [7:0] tmr_value;
    logic       ovf_flag, wdt_timeout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string cur_req = "R1";

    logic [7:0]       m_tmr = '0, m_psc = '0;
    logic [WDT_W-1:0] m_wdt = '0;
    logic             m_ovf = 1'b0, m_to = 1'b0, m_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_presc_timer #(.TMR_W(8), .WDT_W(WDT_W)) i_shared_presc_timer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .wdt_clear(wdt_clear), .mode_cfg(mode_cfg),
        .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data), .ovf_clr(ovf_clr),
        .tmr_value(tmr_value), .ovf_flag(ovf_flag), .wdt_timeout(wdt_timeout)
    );

    function automatic logic [7:0] f_mask(input logic to_wdt, input logic [2:0] code);
        int span;
        span = to_wdt ? (1 << code) : (2 << code);
        return 8'(span - 1);
    endfunction

    function automatic logic f_edge(input logic prev, input logic now, input logic fall);
        return fall ? (prev && !now) : (!prev && now);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance the reference model by one clock using the driven inputs.
    task automatic model_step();
        logic src, pin_in, pout, tev, wev, pclr;
        logic [7:0] mk;
        if (!rst_n) begin
            m_tmr = '0; m_psc = '0; m_wdt = '0; m_ovf = 0; m_to = 0; m_prev = ext_pin;
            return;
        end
        src    = mode_cfg[5] ? f_edge(m_prev, ext_pin, mode_cfg[4]) : cyc_en;
        pin_in = mode_cfg[3] ? wdt_tick : src;
        mk     = f_mask(mode_cfg[3], mode_cfg[2:0]);
        pout   = pin_in && ((m_psc & mk) == mk);
        tev    = mode_cfg[3] ? src : pout;
        wev    = mode_cfg[3] ? pout : wdt_tick;
        pclr   = mode_cfg[3] ? wdt_clear : tmr_wr_en;
        m_ovf  = (!tmr_wr_en && tev && m_tmr == 8'hFF) || (m_ovf && !ovf_clr);
        if (tmr_wr_en) m_tmr = tmr_wr_data; else if (tev) m_tmr = m_tmr + 8'd1;
        if (pclr) m_psc = '0; else if (pin_in) m_psc = m_psc + 8'd1;
        m_to = wev && !wdt_clear && (m_wdt == '1);
        if (wdt_clear) m_wdt = '0; else if (wev) m_wdt = m_wdt + 1'b1;
        m_prev = ext_pin;
    endtask

    task automatic run_cycle();
        model_step();
        @(negedge clk);
        chk(cur_req, tmr_value, m_tmr);
        chk("R7", ovf_flag, m_ovf);
        chk("R8", wdt_timeout, m_to);
    endtask

    task automatic idle_inputs();
        cyc_en = 0; wdt_tick = 0; wdt_clear = 0; tmr_wr_en = 0; ovf_clr = 0;
    endtask

    initial begin : watchdog
        repeat (TIMEOUT_CYC) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = $urandom(20240611);
        idle_inputs(); ext_pin = 0; mode_cfg = 6'h3F; tmr_wr_data = 8'h00; rst_n = 0;
        @(negedge clk);
        run_cycle(); run_cycle();
        chk("R1", tmr_value, 0); chk("R1", ovf_flag, 0); chk("R1", wdt_timeout, 0);
        rst_n = 1;

        // R2: internal source, prescaler to watchdog, timer 1:1
        cur_req = "R2"; mode_cfg = 6'b001000;
        tmr_wr_en = 1; tmr_wr_data = 8'h10; run_cycle(); tmr_wr_en = 0;
        cyc_en = 1; repeat (5) run_cycle();
        chk("R2", tmr_value, 8'h15);

        // R4: prescaler to timer, code 2 -> 1:8
        cur_req = "R4"; mode_cfg = 6'b000010;
        tmr_wr_en = 1; tmr_wr_data = 8'h00; run_cycle(); tmr_wr_en = 0;
        repeat (16) run_cycle(); chk("R4", tmr_value, 2);
        repeat (7) run_cycle();  chk("R4", tmr_value, 2);
        run_cycle();             chk("R4", tmr_value, 3);

        // R6: write restarts the timer-owned prescaler mid-count
        cur_req = "R6";
        repeat (3) run_cycle();
        tmr_wr_en = 1; tmr_wr_data = 8'h40; run_cycle(); tmr_wr_en = 0;
        chk("R6", tmr_value, 8'h40);
        repeat (7) run_cycle(); chk("R6", tmr_value, 8'h40);
        run_cycle();            chk("R6", tmr_value, 8'h41);

        // R7: rollover, hold, clear, and set-beats-clear
        cur_req = "R7"; mode_cfg = 6'b001000;
        tmr_wr_en = 1; tmr_wr_data = 8'hFE; run_cycle(); tmr_wr_en = 0;
        run_cycle(); run_cycle();
        chk("R7", tmr_value, 0); chk("R7", ovf_flag, 1);
        cyc_en = 0; repeat (3) run_cycle(); chk("R7", ovf_flag, 1);
        ovf_clr = 1; run_cycle(); ovf_clr = 0; chk("R7", ovf_flag, 0);
        tmr_wr_en = 1; tmr_wr_data = 8'hFF; run_cycle(); tmr_wr_en = 0;
        cyc_en = 1; ovf_clr = 1; run_cycle(); ovf_clr = 0; cyc_en = 0;
        chk("R7", ovf_flag, 1); chk("R7", tmr_value, 0);

        // R3: external falling, then rising; cyc_en ignored
        cur_req = "R3"; mode_cfg = 6'b111000; cyc_en = 1;
        ext_pin = 1; tmr_wr_en = 1; tmr_wr_data = 8'h00; run_cycle(); tmr_wr_en = 0;
        ext_pin = 0; run_cycle();
        ext_pin = 1; run_cycle();
        chk("R3", tmr_value, 1);
        mode_cfg = 6'b101000;
        ext_pin = 0; run_cycle();
        ext_pin = 1; run_cycle();
        run_cycle();
        chk("R3", tmr_value, 2);
        cyc_en = 0;

        // R5/R8: watchdog owns prescaler, code 0 (1:1) then code 2 (1:4)
        cur_req = "R5"; mode_cfg = 6'b001000;
        wdt_clear = 1; run_cycle(); wdt_clear = 0;
        wdt_tick = 1; repeat (15) run_cycle(); chk("R8", wdt_timeout, 0);
        run_cycle(); chk("R8", wdt_timeout, 1);
        wdt_tick = 0; run_cycle(); chk("R8", wdt_timeout, 0);
        mode_cfg = 6'b001010;
        wdt_clear = 1; tmr_wr_en = 1; tmr_wr_data = 8'h00; run_cycle();
        wdt_clear = 0; tmr_wr_en = 0;
        wdt_tick = 1; cyc_en = 1;
        repeat (63) run_cycle(); chk("R5", wdt_timeout, 0);
        run_cycle(); chk("R5", wdt_timeout, 1);
        chk("R5", tmr_value, 64);
        idle_inputs();

        // R8: clear in the wrapping cycle suppresses the pulse
        cur_req = "R8"; mode_cfg = 6'b001000;
        wdt_clear = 1; run_cycle(); wdt_clear = 0;
        wdt_tick = 1; repeat (15) run_cycle();
        wdt_clear = 1; run_cycle(); wdt_clear = 0; wdt_tick = 0;
        chk("R8", wdt_timeout, 0);

        // Randomized mix
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            if (i % 150 == 0) mode_cfg = 6'($urandom);
            cyc_en      = $urandom_range(0, 3) != 0;
            ext_pin     = $urandom_range(0, 1);
            wdt_tick    = $urandom_range(0, 1);
            wdt_clear   = $urandom_range(0, 40) == 0;
            tmr_wr_en   = $urandom_range(0, 30) == 0;
            tmr_wr_data = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
            ovf_clr     = $urandom_range(0, 20) == 0;
            run_cycle();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule